// File: doc/BRIEF.md
# Translation Unit Control Register Block

This block is the software-visible control face of a two-level address translation unit. A 32-bit register port sets the directory base pointer, issues write-only commands, and reads back status, the captured faulting address and the interrupt state. Behind it sit a table walker and a translation cache. Neither is part of this block. The block drives their control lines: translation enable, stall, directory base, a whole-cache flush strobe, a single-entry invalidate strobe and a fault-resume strobe. The walker reports translation faults and bus read errors back into the block.

The paging and stall state changes only through command codes. A stall request is honoured only while translation is on. The fault unit keeps the first faulting address until software acknowledges it. Interrupt sources latch in a raw register, pass through a mask, and combine into a single interrupt line. A forced-reset command returns every register to its power-on value without touching the hardware reset.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset the status word (offset 0x04) reads with only bit 31 (stall not active), bit 3 (walker idle input) and bit 4 (replay empty input) able to be set. The directory base reads 0, and the interrupt and translation outputs are low.
- R2: The directory base register (offset 0x00) keeps only bits 31:12 of a write. Writing 0xCAFEBABE reads back as 0xCAFEB000, and that value drives the directory base output.
- R3: Command register (offset 0x08, code in bits 2:0). Code 0 turns translation on and code 1 turns it off. Status bit 0 and the paging output follow from the cycle after the write. Code 1 also drops any stall.
- R4: Code 2 sets stall (status bit 2, bit 31 cleared) only if translation is already on; otherwise it changes nothing. Code 3 clears stall.
- R5: Code 4 raises the flush output for exactly one cycle, the cycle after the write. A write to offset 0x10 raises the invalidate strobe for exactly one cycle and presents the written word on the invalidate address output.
- R6: A fault event sets status bit 1 and raw interrupt bit 0. It captures its address at offset 0x0C and its write flag in status bit 5. A further fault while one is active changes neither the address nor the flag.
- R7: Code 5 clears the fault-active bit and pulses the resume output for one cycle. The next fault is captured afresh.
- R8: A bus-error event sets raw bit 1 (raw at offset 0x14). The mask sits at offset 0x1C. Offset 0x20 reads raw AND mask, and the interrupt output is the OR of those bits. Writing ones to offset 0x18 clears raw bits, except that an event arriving in the same cycle keeps its bit set.
- R9: Code 6 returns every register to its reset value: base, paging, stall, mask, raw, fault state, fault address and gating.
- R10: Offset 0x24 bit 0 is a read/write clock-gating enable that drives its output.
- R11: Code 7, and writes to the read-only offsets 0x04 and 0x20, change nothing. The command offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| walk_idle_i | input | 1 | Walker idle, shown in status bit 3 |
| replay_empty_i | input | 1 | Replay buffer empty, shown in status bit 4 |
| fault_evt_i | input | 1 | Translation fault event (one cycle) |
| fault_addr_i | input | 32 | Address of the faulting access |
| fault_wr_i | input | 1 | Faulting access was a write |
| buserr_evt_i | input | 1 | Bus read error event (one cycle) |
| paging_en_o | output | 1 | Translation enabled |
| stall_o | output | 1 | Stall active |
| dir_base_o | output | 32 | Directory base address |
| flush_all_o | output | 1 | Whole-cache flush strobe |
| inval_vld_o | output | 1 | Single-entry invalidate strobe |
| inval_addr_o | output | 32 | Address for the invalidate |
| fault_resume_o | output | 1 | Fault acknowledged, walker may resume |
| gate_en_o | output | 1 | Clock-gating enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench issues a stall request while translation is off. A design that accepted it would show status bit 2 with nothing to stall. It sends a second fault while the first is still pending. A design that overwrote the capture would report the wrong address to software. It clears a raw bit in the same cycle as a new bus error, which catches a design where the clear wins and the event is lost. It also checks that the flush, invalidate and resume strobes drop after one cycle, and that the forced reset clears the mask, raw bits and gating as well as the base register.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned REG_AW  = 6;
    localparam int unsigned CMD_W   = 3;
    localparam int unsigned NUM_IRQ = 2;
    localparam int unsigned IRQ_FAULT  = 0;
    localparam int unsigned IRQ_BUSERR = 1;

    typedef enum logic [CMD_W-1:0] {
        CMD_PAGE_ON   = 3'd0,
        CMD_PAGE_OFF  = 3'd1,
        CMD_STALL_ON  = 3'd2,
        CMD_STALL_OFF = 3'd3,
        CMD_FLUSH     = 3'd4,
        CMD_FAULT_ACK = 3'd5,
        CMD_HARD_RST  = 3'd6,
        CMD_NONE      = 3'd7
    } cmd_e;

    localparam logic [REG_AW-1:0] OFS_BASE  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_STAT  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_CMD   = 6'h08;
    localparam logic [REG_AW-1:0] OFS_FADDR = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_INVAL = 6'h10;
    localparam logic [REG_AW-1:0] OFS_RAW   = 6'h14;
    localparam logic [REG_AW-1:0] OFS_CLR   = 6'h18;
    localparam logic [REG_AW-1:0] OFS_MASK  = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_MSTAT = 6'h20;
    localparam logic [REG_AW-1:0] OFS_GATE  = 6'h24;
endpackage

// File: rtl/xlat_mode_ctl.sv
module xlat_mode_ctl
    import xlat_ctl_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              base_we,
    input  logic              gate_we,
    input  logic              inval_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              paging_o,
    output logic              stall_o,
    output logic [DATA_W-1:0] base_o,
    output logic              gate_o,
    output logic              flush_o,
    output logic              inval_vld_o,
    output logic [DATA_W-1:0] inval_addr_o
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic              paging;
        logic              stall;
        logic [DATA_W-1:0] base;
        logic              gate;
        logic              flush;
        logic              inval_vld;
        logic [DATA_W-1:0] inval_addr;
    } mode_t;

    mode_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.flush     = 1'b0;
        s_d.inval_vld = 1'b0;
        if (base_we)
            s_d.base = {wdata[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        if (gate_we)
            s_d.gate = wdata[0];
        if (inval_we) begin
            s_d.inval_vld  = 1'b1;
            s_d.inval_addr = wdata;
        end
        if (cmd_we) begin
            case (cmd_e'(cmd_code))
                CMD_PAGE_ON:   s_d.paging = 1'b1;
                CMD_PAGE_OFF: begin
                    s_d.paging = 1'b0;
                    s_d.stall  = 1'b0;
                end
                CMD_STALL_ON:  if (s_q.paging) s_d.stall = 1'b1;
                CMD_STALL_OFF: s_d.stall = 1'b0;
                CMD_FLUSH:     s_d.flush = 1'b1;
                CMD_HARD_RST:  s_d = '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign paging_o     = s_q.paging;
    assign stall_o      = s_q.stall;
    assign base_o       = s_q.base;
    assign gate_o       = s_q.gate;
    assign flush_o      = s_q.flush;
    assign inval_vld_o  = s_q.inval_vld;
    assign inval_addr_o = s_q.inval_addr;

    p_stall_needs_paging_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> paging_o);
    p_stall_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_code == CMD_STALL_ON && !paging_o) |=> !stall_o);
    p_flush_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_code == CMD_FLUSH) |=> flush_o);
    p_hard_rst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_code == CMD_HARD_RST) |=> (base_o == '0 && !paging_o && !gate_o));
endmodule

// File: rtl/xlat_fault_irq.sv
module xlat_fault_irq
    import xlat_ctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hard_rst,
    input  logic               ack,
    input  logic               clr_we,
    input  logic               mask_we,
    input  logic [NUM_IRQ-1:0] wbits,
    input  logic               fault_evt,
    input  logic [DATA_W-1:0]  fault_addr_i,
    input  logic               fault_wr_i,
    input  logic               buserr_evt,
    output logic               fault_act_o,
    output logic               fault_wr_o,
    output logic [DATA_W-1:0]  fault_addr_o,
    output logic [NUM_IRQ-1:0] raw_o,
    output logic [NUM_IRQ-1:0] mask_o,
    output logic               resume_o,
    output logic               irq_o
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic               act;
        logic               is_wr;
        logic [DATA_W-1:0]  addr;
        logic [NUM_IRQ-1:0] raw;
        logic [NUM_IRQ-1:0] mask;
        logic               resume;
    } flt_t;

    flt_t s_d, s_q;
    logic [NUM_IRQ-1:0] ev;

    always_comb begin
        ev             = '0;
        ev[IRQ_FAULT]  = fault_evt;
        ev[IRQ_BUSERR] = buserr_evt;

        s_d        = s_q;
        s_d.resume = 1'b0;
        if (clr_we)  s_d.raw  = s_q.raw & ~wbits;
        if (mask_we) s_d.mask = wbits;
        if (ack) begin
            s_d.act    = 1'b0;
            s_d.resume = 1'b1;
        end
        s_d.raw = s_d.raw | ev;
        if (fault_evt && (!s_q.act || ack)) begin
            s_d.act   = 1'b1;
            s_d.addr  = fault_addr_i;
            s_d.is_wr = fault_wr_i;
        end
        if (hard_rst) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fault_act_o  = s_q.act;
    assign fault_wr_o   = s_q.is_wr;
    assign fault_addr_o = s_q.addr;
    assign raw_o        = s_q.raw;
    assign mask_o       = s_q.mask;
    assign resume_o     = s_q.resume;
    assign irq_o        = |(s_q.raw & s_q.mask);

    p_fault_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_act_o && fault_evt && !ack && !hard_rst) |=> $stable(fault_addr_o));
    p_ack_resumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hard_rst && !fault_evt) |=> (resume_o && !fault_act_o));
    p_clear_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wbits[IRQ_FAULT] && !fault_evt && !hard_rst) |=> !raw_o[IRQ_FAULT]);
    p_buserr_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buserr_evt && !hard_rst) |=> raw_o[IRQ_BUSERR]);
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
    import xlat_ctl_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              walk_idle_i,
    input  logic              replay_empty_i,
    input  logic              fault_evt_i,
    input  logic [DATA_W-1:0] fault_addr_i,
    input  logic              fault_wr_i,
    input  logic              buserr_evt_i,
    output logic              paging_en_o,
    output logic              stall_o,
    output logic [DATA_W-1:0] dir_base_o,
    output logic              flush_all_o,
    output logic              inval_vld_o,
    output logic [DATA_W-1:0] inval_addr_o,
    output logic              fault_resume_o,
    output logic              gate_en_o,
    output logic              irq_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic               cmd_we, hard_rst, ack;
    logic               fault_act, fault_wr;
    logic [DATA_W-1:0]  fault_addr;
    logic [NUM_IRQ-1:0] raw, mask;

    assign cmd_we   = reg_we && (reg_addr == OFS_CMD);
    assign hard_rst = cmd_we && (reg_wdata[CMD_W-1:0] == CMD_HARD_RST);
    assign ack      = cmd_we && (reg_wdata[CMD_W-1:0] == CMD_FAULT_ACK);

    xlat_mode_ctl #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_code     (reg_wdata[CMD_W-1:0]),
        .base_we      (reg_we && reg_addr == OFS_BASE),
        .gate_we      (reg_we && reg_addr == OFS_GATE),
        .inval_we     (reg_we && reg_addr == OFS_INVAL),
        .wdata        (reg_wdata),
        .paging_o     (paging_en_o),
        .stall_o      (stall_o),
        .base_o       (dir_base_o),
        .gate_o       (gate_en_o),
        .flush_o      (flush_all_o),
        .inval_vld_o  (inval_vld_o),
        .inval_addr_o (inval_addr_o)
    );

    xlat_fault_irq #(.DATA_W(DATA_W)) u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .hard_rst     (hard_rst),
        .ack          (ack),
        .clr_we       (reg_we && reg_addr == OFS_CLR),
        .mask_we      (reg_we && reg_addr == OFS_MASK),
        .wbits        (reg_wdata[NUM_IRQ-1:0]),
        .fault_evt    (fault_evt_i),
        .fault_addr_i (fault_addr_i),
        .fault_wr_i   (fault_wr_i),
        .buserr_evt   (buserr_evt_i),
        .fault_act_o  (fault_act),
        .fault_wr_o   (fault_wr),
        .fault_addr_o (fault_addr),
        .raw_o        (raw),
        .mask_o       (mask),
        .resume_o     (fault_resume_o),
        .irq_o        (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_BASE:  reg_rdata = dir_base_o;
            OFS_STAT: begin
                reg_rdata[0]        = paging_en_o;
                reg_rdata[1]        = fault_act;
                reg_rdata[2]        = stall_o;
                reg_rdata[3]        = walk_idle_i;
                reg_rdata[4]        = replay_empty_i;
                reg_rdata[5]        = fault_wr;
                reg_rdata[DATA_W-1] = ~stall_o;
            end
            OFS_FADDR: reg_rdata = fault_addr;
            OFS_RAW:   reg_rdata[NUM_IRQ-1:0] = raw;
            OFS_MASK:  reg_rdata[NUM_IRQ-1:0] = mask;
            OFS_MSTAT: reg_rdata[NUM_IRQ-1:0] = raw & mask;
            OFS_GATE:  reg_rdata[0] = gate_en_o;
            default: ;
        endcase
    end

    p_paging_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && reg_wdata[CMD_W-1:0] == CMD_PAGE_ON) |=> paging_en_o);
endmodule

// File: tb/xlat_ctl_regs_test.sv
module xlat_ctl_regs_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fault_evt = 1'b0, fault_wr = 1'b0, buserr = 1'b0;
    logic [31:0] fault_addr = '0;
    logic        paging_en, stall, flush_all, inval_vld, resume, gate_en, irq;
    logic [31:0] dir_base, inval_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam int S_RD = 0, S_FLUSH = 1, S_INV = 2, S_INVA = 3, S_IRQ = 4,
                   S_RES = 5, S_GATE = 6, S_PAGE = 7, S_BASE = 8;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];
    item_t it;
    logic [31:0] got;

    always #2 clk = ~clk;

    xlat_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .walk_idle_i(1'b1), .replay_empty_i(1'b1),
        .fault_evt_i(fault_evt), .fault_addr_i(fault_addr), .fault_wr_i(fault_wr),
        .buserr_evt_i(buserr), .paging_en_o(paging_en), .stall_o(stall),
        .dir_base_o(dir_base), .flush_all_o(flush_all), .inval_vld_o(inval_vld),
        .inval_addr_o(inval_addr), .fault_resume_o(resume), .gate_en_o(gate_en),
        .irq_o(irq)
    );

    function automatic logic [31:0] pick(int sel);
        case (sel)
            S_RD:    return reg_rdata;
            S_FLUSH: return {31'd0, flush_all};
            S_INV:   return {31'd0, inval_vld};
            S_INVA:  return inval_addr;
            S_IRQ:   return {31'd0, irq};
            S_RES:   return {31'd0, resume};
            S_GATE:  return {31'd0, gate_en};
            S_PAGE:  return {30'd0, stall, paging_en};
            default: return dir_base;
        endcase
    endfunction

    // monitor: compares queued expectations shortly after each falling edge
    initial forever begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            it  = q.pop_front();
            got = pick(it.sel);
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
            end
        end
    end

    task automatic chk(int sel, logic [5:0] a, logic [31:0] e, string tag);
        reg_addr = a;
        q.push_back('{sel, e, tag});
        @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic fault(logic [31:0] a, logic w);
        @(negedge clk);
        fault_evt = 1'b1; fault_addr = a; fault_wr = w;
        @(negedge clk);
        fault_evt = 1'b0;
    endtask

    task automatic bus_error();
        @(negedge clk);
        buserr = 1'b1;
        @(negedge clk);
        buserr = 1'b0;
    endtask

    task automatic clear_with_buserr(logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'h18; reg_wdata = d; buserr = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; buserr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(S_RD, 6'h04, 32'h8000_0018, "R1 status");
        chk(S_RD, 6'h00, 32'h0, "R1 base");
        chk(S_IRQ, 6'h00, 32'h0, "R1 irq");
        chk(S_PAGE, 6'h00, 32'h0, "R1 paging/stall");
        // R2 base truncation
        wr(6'h00, 32'hCAFE_BABE);
        chk(S_RD, 6'h00, 32'hCAFE_B000, "R2 base readback");
        chk(S_BASE, 6'h00, 32'hCAFE_B000, "R2 base port");
        // R4 stall refused with paging off
        wr(6'h08, 32'd2);
        chk(S_RD, 6'h04, 32'h8000_0018, "R4 stall refused");
        // R3 paging on
        wr(6'h08, 32'd0);
        chk(S_RD, 6'h04, 32'h8000_0019, "R3 paging on status");
        chk(S_PAGE, 6'h00, 32'h1, "R3 paging port");
        // R4 stall on/off
        wr(6'h08, 32'd2);
        chk(S_RD, 6'h04, 32'h0000_001D, "R4 stall on");
        wr(6'h08, 32'd3);
        chk(S_RD, 6'h04, 32'h8000_0019, "R4 stall off");
        // R3 paging off drops stall
        wr(6'h08, 32'd2);
        wr(6'h08, 32'd1);
        chk(S_RD, 6'h04, 32'h8000_0018, "R3 paging off drops stall");
        wr(6'h08, 32'd0);
        // R5 strobes
        wr(6'h08, 32'd4);
        chk(S_FLUSH, 6'h00, 32'h1, "R5 flush high");
        chk(S_FLUSH, 6'h00, 32'h0, "R5 flush one cycle");
        wr(6'h10, 32'h1234_5000);
        chk(S_INV, 6'h00, 32'h1, "R5 inval high");
        chk(S_INV, 6'h00, 32'h0, "R5 inval one cycle");
        chk(S_INVA, 6'h00, 32'h1234_5000, "R5 inval addr");
        // R6 fault capture
        fault(32'h0040_3000, 1'b1);
        chk(S_RD, 6'h0C, 32'h0040_3000, "R6 fault addr");
        chk(S_RD, 6'h04, 32'h8000_003B, "R6 status fault");
        chk(S_RD, 6'h14, 32'h1, "R6 raw fault bit");
        fault(32'h0077_7000, 1'b0);
        chk(S_RD, 6'h0C, 32'h0040_3000, "R6 second fault keeps addr");
        chk(S_RD, 6'h04, 32'h8000_003B, "R6 second fault keeps flag");
        // R8 interrupts
        chk(S_IRQ, 6'h00, 32'h0, "R8 masked off");
        wr(6'h1C, 32'h3);
        chk(S_IRQ, 6'h00, 32'h1, "R8 irq on mask");
        chk(S_RD, 6'h20, 32'h1, "R8 masked status");
        bus_error();
        chk(S_RD, 6'h14, 32'h3, "R8 buserr raw");
        wr(6'h1C, 32'h2);
        chk(S_RD, 6'h20, 32'h2, "R8 masked partial");
        wr(6'h18, 32'h1);
        chk(S_RD, 6'h14, 32'h2, "R8 clear bit0");
        clear_with_buserr(32'h2);
        chk(S_RD, 6'h14, 32'h2, "R8 event beats clear");
        wr(6'h18, 32'h2);
        chk(S_RD, 6'h14, 32'h0, "R8 clear bit1");
        chk(S_IRQ, 6'h00, 32'h0, "R8 irq low");
        // R7 fault acknowledge
        wr(6'h08, 32'd5);
        chk(S_RES, 6'h00, 32'h1, "R7 resume high");
        chk(S_RES, 6'h00, 32'h0, "R7 resume one cycle");
        chk(S_RD, 6'h04, 32'h8000_0039, "R7 fault cleared");
        fault(32'h0099_9000, 1'b0);
        chk(S_RD, 6'h0C, 32'h0099_9000, "R7 new capture");
        // R10 gating
        wr(6'h24, 32'h1);
        chk(S_GATE, 6'h00, 32'h1, "R10 gate port");
        chk(S_RD, 6'h24, 32'h1, "R10 gate read");
        // R11 ignored writes
        wr(6'h08, 32'd7);
        chk(S_RD, 6'h04, 32'h8000_001B, "R11 code 7 no effect");
        wr(6'h04, 32'hFFFF_FFFF);
        chk(S_RD, 6'h04, 32'h8000_001B, "R11 status read-only");
        chk(S_RD, 6'h08, 32'h0, "R11 command reads zero");
        wr(6'h20, 32'hFFFF_FFFF);
        chk(S_RD, 6'h1C, 32'h2, "R11 masked write ignored");
        // R9 forced reset
        wr(6'h08, 32'd6);
        chk(S_RD, 6'h00, 32'h0, "R9 base cleared");
        chk(S_RD, 6'h04, 32'h8000_0018, "R9 status reset");
        chk(S_RD, 6'h1C, 32'h0, "R9 mask cleared");
        chk(S_RD, 6'h14, 32'h0, "R9 raw cleared");
        chk(S_RD, 6'h0C, 32'h0, "R9 fault addr cleared");
        chk(S_GATE, 6'h00, 32'h0, "R9 gate cleared");
        @(negedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule